// File: doc/BRIEF.md
# Clock Output Gating and Stop Control

This block sits between a set of already generated clocks and the pins that carry them off the chip. Every clock output has a configuration enable bit. That bit is brought into the domain of the clock it controls and then applied only while that clock is low. A cleared bit therefore parks the output low without cutting a high phase short.

One group of PCI clocks also obeys an active-low stop input. That input is sampled on the free-running PCI clock, and the free-running PCI clock itself never stops. The stop input exists only when a static strap selects it. Otherwise the shared pin carries a gated reference clock.

Separately from the clock values, the block produces a drive control for each pin. A low output-enable pin releases every pin to high impedance, and so does the all-outputs-three-state code in the configuration mode field. A disabled output is different: it is driven low, not released.

Top module: `clkout_gate_ctrl`

## Requirements
- R1: While `rst_n` is low, every clock value output is 0 and the stop state reads as "run".
- R2: An output whose enable bit is 1 follows its source clock, and one whose bit is 0 is held at 0. A change of the bit takes effect at the falling edge that follows SYNC_STAGES rising edges of that output's clock. No high phase is ever shortened.
- R3: `pci_stop_n` is sampled on each rising edge of `clk_pcif`. A 0 sampled at edge k holds `pci_o` at 0 from the high phase that starts at edge k+1. A 1 sampled at edge k lets the outputs run again from edge k+1.
- R4: `pcif_o` depends only on `cfg_pcif_en` and `clk_pcif`. The stop input never affects it.
- R5: With `strap_stop_sel` = 0 the stop input is ignored, and `pci_o` runs whatever level `pci_stop_n` has.
- R6: With `oe_pin` = 0 every drive control output is 0 (high impedance). With `oe_pin` = 1 the drive controls are 1, unless R7 or R8 applies.
- R7: `cfg_mode` = 2'b11 forces every drive control to 0. The codes 2'b00, 2'b01 and 2'b10 leave the drive controls at 1.
- R8: With `strap_stop_sel` = 1 the shared pin is an input, so `ref_drv_o` = 0 and `ref_o` = 0. With the strap at 0, `ref_o` is `clk_ref` gated per R2 by `cfg_ref_en`, and `ref_drv_o` follows R6 and R7.
- R9: Drive controls and clock values are independent. A pin released by R6 or R7 keeps its clock value running, and a disabled pin stays driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_pcif | input | 1 | Free-running PCI source clock; also samples the stop input |
| clk_gen | input | N_GEN | Source clocks of the general outputs |
| clk_ref | input | 1 | Reference source clock for the shared pin |
| cfg_gen_en | input | N_GEN | Enable bits of the general outputs (1 = run) |
| cfg_pcif_en | input | 1 | Enable bit of the free-running PCI output |
| cfg_pci_en | input | N_STOP | Enable bits of the stoppable PCI outputs |
| cfg_ref_en | input | 1 | Enable bit of the reference output |
| cfg_mode | input | 2 | Output mode field; 2'b11 = all three-state |
| strap_stop_sel | input | 1 | Static strap: 1 makes the shared pin the stop input |
| pci_stop_n | input | 1 | Active-low stop for the stoppable PCI group |
| oe_pin | input | 1 | Global output enable, asynchronous |
| gen_o | output | N_GEN | Gated general clock values |
| gen_drv_o | output | N_GEN | Drive controls of the general pins |
| pcif_o | output | 1 | Gated free-running PCI clock value |
| pcif_drv_o | output | 1 | Drive control of the free-running PCI pin |
| pci_o | output | N_STOP | Gated stoppable PCI clock values |
| pci_drv_o | output | N_STOP | Drive controls of the stoppable PCI pins |
| ref_o | output | 1 | Gated reference clock value |
| ref_drv_o | output | 1 | Drive control of the shared reference/stop pin |

## Verification
The hardest case to reach is the exact one-cycle latency of the stop input. The level has to be changed in the low phase just before a chosen rising edge, and the outputs have to be observed in both that high phase and the next one, with every PCI enable already settled through its synchronizer. The bench applies the stop level at a falling edge and then samples one nanosecond into each of the next two high phases. A second clock at half the rate makes the per-domain resynchronisation latency differ between outputs. A fresh reset with the strap cleared shows the stop level being ignored.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

   // Output mode field; only the all-release code has an effect here.
   typedef enum logic [1:0] {
      OM_NORMAL_A = 2'b00,
      OM_SPARE    = 2'b01,
      OM_NORMAL_B = 2'b10,
      OM_RELEASE  = 2'b11
   } out_mode_e;

   function automatic logic pins_driven(input logic oe, input logic [1:0] mode);
      return oe && (out_mode_e'(mode) != OM_RELEASE);
   endfunction

endpackage

// File: rtl/cg_sync.sv
`timescale 1ns/1ps
module cg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_depth
      $error("cg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/cg_gate.sv
`timescale 1ns/1ps
module cg_gate #(
   parameter int STAGES = 2,
   parameter bit RESYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_cfg,
   input  logic run,
   output logic clk_o
);

   logic en_dom;
   logic en_low;

   if (RESYNC) begin : g_resync
      cg_sync #(.STAGES(STAGES)) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (en_cfg),
         .q     (en_dom)
      );
   end else begin : g_direct
      assign en_dom = en_cfg;
   end

   // Enable only moves while the clock is low.
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) en_low <= 1'b0;
      else        en_low <= en_dom & run;
   end

   assign clk_o = clk & en_low;

   AST_GATE_PASSES: assert property (@(negedge clk) disable iff (!rst_n)
      $past(en_dom & run) |-> clk_o);                              // R2
   AST_GATE_PARKED: assert property (@(negedge clk) disable iff (!rst_n)
      !$past(en_dom & run) |-> !clk_o);                            // R2

endmodule

// File: rtl/cg_drive.sv
`timescale 1ns/1ps
module cg_drive
   import clkgate_pkg::*;
#(
   parameter int N_PINS = 8
) (
   input  logic              oe_pin,
   input  logic [1:0]        mode,
   input  logic              ref_is_input,
   output logic [N_PINS-1:0] drv_o,
   output logic              ref_drv_o
);

   if (N_PINS < 1) begin : g_bad_pins
      $error("cg_drive: N_PINS must be at least 1");
   end

   logic drive_all;
   assign drive_all = pins_driven(oe_pin, mode);

   for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      assign drv_o[p] = drive_all;
   end

   assign ref_drv_o = drive_all & ~ref_is_input;

endmodule

// File: rtl/clkout_gate_ctrl.sv
`timescale 1ns/1ps
module clkout_gate_ctrl
   import clkgate_pkg::*;
#(
   parameter int N_GEN       = 2,
   parameter int N_STOP      = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit CFG_RESYNC  = 1'b1
) (
   input  logic              rst_n,
   input  logic              clk_pcif,
   input  logic [N_GEN-1:0]  clk_gen,
   input  logic              clk_ref,
   input  logic [N_GEN-1:0]  cfg_gen_en,
   input  logic              cfg_pcif_en,
   input  logic [N_STOP-1:0] cfg_pci_en,
   input  logic              cfg_ref_en,
   input  logic [1:0]        cfg_mode,
   input  logic              strap_stop_sel,
   input  logic              pci_stop_n,
   input  logic              oe_pin,
   output logic [N_GEN-1:0]  gen_o,
   output logic [N_GEN-1:0]  gen_drv_o,
   output logic              pcif_o,
   output logic              pcif_drv_o,
   output logic [N_STOP-1:0] pci_o,
   output logic [N_STOP-1:0] pci_drv_o,
   output logic              ref_o,
   output logic              ref_drv_o
);

   localparam int N_PINS   = N_GEN + N_STOP + 1;
   localparam int PCIF_IDX = N_GEN;
   localparam int PCI_LO   = N_GEN + 1;

   if (N_GEN < 1 || N_STOP < 1) begin : g_bad_counts
      $error("clkout_gate_ctrl: N_GEN and N_STOP must be at least 1");
   end

   // Stop state, sampled on the free-running PCI clock.
   logic run_q;
   always_ff @(posedge clk_pcif or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b1;
      else        run_q <= strap_stop_sel ? pci_stop_n : 1'b1;
   end

   for (genvar g = 0; g < N_GEN; g++) begin : g_gen
      cg_gate #(.STAGES(SYNC_STAGES), .RESYNC(CFG_RESYNC)) u_gate (
         .clk (clk_gen[g]), .rst_n (rst_n), .en_cfg (cfg_gen_en[g]),
         .run (1'b1), .clk_o (gen_o[g])
      );
   end

   cg_gate #(.STAGES(SYNC_STAGES), .RESYNC(CFG_RESYNC)) u_pcif_gate (
      .clk (clk_pcif), .rst_n (rst_n), .en_cfg (cfg_pcif_en),
      .run (1'b1), .clk_o (pcif_o)
   );

   for (genvar s = 0; s < N_STOP; s++) begin : g_stop
      cg_gate #(.STAGES(SYNC_STAGES), .RESYNC(CFG_RESYNC)) u_gate (
         .clk (clk_pcif), .rst_n (rst_n), .en_cfg (cfg_pci_en[s]),
         .run (run_q), .clk_o (pci_o[s])
      );
   end

   cg_gate #(.STAGES(SYNC_STAGES), .RESYNC(CFG_RESYNC)) u_ref_gate (
      .clk (clk_ref), .rst_n (rst_n), .en_cfg (cfg_ref_en),
      .run (~strap_stop_sel), .clk_o (ref_o)
   );

   logic [N_PINS-1:0] drv_all;
   cg_drive #(.N_PINS(N_PINS)) u_drive (
      .oe_pin       (oe_pin),
      .mode         (cfg_mode),
      .ref_is_input (strap_stop_sel),
      .drv_o        (drv_all),
      .ref_drv_o    (ref_drv_o)
   );

   assign gen_drv_o  = drv_all[N_GEN-1:0];
   assign pcif_drv_o = drv_all[PCIF_IDX];
   assign pci_drv_o  = drv_all[PCI_LO +: N_STOP];

   AST_STOP_PARKS_GROUP: assert property (@(negedge clk_pcif) disable iff (!rst_n)
      !$past(run_q) |-> (pci_o == '0));                                         // R3
   AST_UNSTRAPPED_RUNS: assert property (@(posedge clk_pcif) disable iff (!rst_n)
      !strap_stop_sel |=> run_q);                                               // R5
   AST_OE_RELEASES: assert property (@(negedge clk_pcif) disable iff (!rst_n)
      !oe_pin |-> !(|{gen_drv_o, pcif_drv_o, pci_drv_o, ref_drv_o}));           // R6
   AST_MODE_RELEASES: assert property (@(negedge clk_pcif) disable iff (!rst_n)
      (cfg_mode == 2'b11) |-> !(|{gen_drv_o, pcif_drv_o, pci_drv_o, ref_drv_o})); // R7
   AST_SHARED_PIN_INPUT: assert property (@(negedge clk_pcif) disable iff (!rst_n)
      strap_stop_sel |-> !ref_drv_o);                                           // R8

endmodule

// File: tb/clkout_gate_ctrl_bench.sv
`timescale 1ns/1ps
module clkout_gate_ctrl_bench;

   localparam int NG = 2;
   localparam int NS = 5;
   localparam int SS = 2;

   logic clk = 1'b0, clk2 = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;
   always @(posedge clk) clk2 <= ~clk2;

   logic [NG-1:0] cfg_gen_en = '1;
   logic          cfg_pcif_en = 1'b1;
   logic [NS-1:0] cfg_pci_en = '1;
   logic          cfg_ref_en = 1'b1;
   logic [1:0]    cfg_mode = 2'b00;
   logic          strap = 1'b1, stop_n = 1'b1, oe = 1'b1;

   logic [NG-1:0] gen_o, gen_drv_o;
   logic          pcif_o, pcif_drv_o, ref_o, ref_drv_o;
   logic [NS-1:0] pci_o, pci_drv_o;

   clkout_gate_ctrl #(.N_GEN(NG), .N_STOP(NS), .SYNC_STAGES(SS)) u_clkout_gate_ctrl (
      .rst_n (rst_n), .clk_pcif (clk), .clk_gen ({clk2, clk}), .clk_ref (clk2),
      .cfg_gen_en (cfg_gen_en), .cfg_pcif_en (cfg_pcif_en), .cfg_pci_en (cfg_pci_en),
      .cfg_ref_en (cfg_ref_en), .cfg_mode (cfg_mode), .strap_stop_sel (strap),
      .pci_stop_n (stop_n), .oe_pin (oe),
      .gen_o (gen_o), .gen_drv_o (gen_drv_o), .pcif_o (pcif_o), .pcif_drv_o (pcif_drv_o),
      .pci_o (pci_o), .pci_drv_o (pci_drv_o), .ref_o (ref_o), .ref_drv_o (ref_drv_o)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Reference model. Fast domain bits: {pci[4:0], pcif, gen0}. Slow domain: {ref, gen1}.
   wire [NS+1:0] cfg_a = {cfg_pci_en, cfg_pcif_en, cfg_gen_en[0]};
   wire [1:0]    cfg_b = {cfg_ref_en, cfg_gen_en[1]};
   logic [NS+1:0] seen_a [SS];
   logic [1:0]    seen_b [SS];
   logic [NS+1:0] live_a;
   logic [1:0]    live_b;
   logic          run_m;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SS; i++) seen_a[i] <= '0;
         run_m <= 1'b1;
      end else begin
         seen_a[0] <= cfg_a;
         for (int i = 1; i < SS; i++) seen_a[i] <= seen_a[i-1];
         run_m <= strap ? stop_n : 1'b1;
      end
   end
   always @(negedge clk or negedge rst_n) begin
      if (!rst_n) live_a <= '0;
      else        live_a <= seen_a[SS-1] & {{NS{run_m}}, 2'b11};
   end
   always @(posedge clk2 or negedge rst_n) begin
      if (!rst_n) for (int i = 0; i < SS; i++) seen_b[i] <= '0;
      else begin
         seen_b[0] <= cfg_b;
         for (int i = 1; i < SS; i++) seen_b[i] <= seen_b[i-1];
      end
   end
   always @(negedge clk2 or negedge rst_n) begin
      if (!rst_n) live_b <= '0;
      else        live_b <= seen_b[SS-1] & {~strap, 1'b1};
   end

   // Compare on every clock edge, one nanosecond after it.
   always @(clk) begin
      #1;
      if (rst_n && !done) begin
         logic [NS+1:0] ea;
         logic [1:0]    eb;
         logic          d;
         ea = clk  ? live_a : '0;
         eb = clk2 ? live_b : '0;
         d  = oe && (cfg_mode != 2'b11);
         chk({gen_o[1], gen_o[0]} == {eb[0], ea[0]}, "R2 gen", {gen_o}, {eb[0], ea[0]});
         chk(pcif_o == ea[1], "R4 pcif", pcif_o, ea[1]);
         chk(pci_o == ea[NS+1:2], "R3 pci", pci_o, ea[NS+1:2]);
         chk(ref_o == eb[1], "R8 ref", ref_o, eb[1]);
         chk({gen_drv_o, pcif_drv_o, pci_drv_o} == {(NG+NS+1){d}}, "R6 drv",
             {gen_drv_o, pcif_drv_o, pci_drv_o}, {(NG+NS+1){d}});
         chk(ref_drv_o == (d && !strap), "R8 ref_drv", ref_drv_o, d && !strap);
      end
   end

   task automatic at_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      // R1: reset state
      at_neg(4);
      #1;
      chk({gen_o, pcif_o, pci_o, ref_o} == '0, "R1 values in reset", {gen_o, pcif_o, pci_o, ref_o}, 0);
      @(posedge clk); #1;
      chk({gen_o, pcif_o, pci_o, ref_o} == '0, "R1 high phase in reset", {gen_o, pcif_o, pci_o, ref_o}, 0);
      at_neg(1); #1; rst_n = 1'b1;
      at_neg(12);

      // R2: per-output enables, several patterns
      cfg_pci_en = 5'b01010; cfg_gen_en = 2'b10; at_neg(8);
      cfg_pci_en = 5'b10101; cfg_gen_en = 2'b01; cfg_ref_en = 1'b0; at_neg(8);
      cfg_pcif_en = 1'b0; at_neg(6);
      @(posedge clk); #1;
      chk(pcif_o == 1'b0, "R2 disabled pcif low in high phase", pcif_o, 0);
      at_neg(1);
      cfg_pcif_en = 1'b1; cfg_pci_en = '1; cfg_gen_en = '1; cfg_ref_en = 1'b1; at_neg(8);

      // R3: exact stop latency
      stop_n = 1'b0;
      @(posedge clk); #1;
      chk(pci_o == '1, "R3 running in edge-k high phase", pci_o, 5'h1f);
      @(posedge clk); #1;
      chk(pci_o == '0, "R3 parked from edge k+1", pci_o, 0);
      chk(pcif_o == 1'b1, "R4 free clock unaffected by stop", pcif_o, 1);
      at_neg(4);
      stop_n = 1'b1;
      @(posedge clk); #1;
      chk(pci_o == '0, "R3 still parked at edge k", pci_o, 0);
      @(posedge clk); #1;
      chk(pci_o == '1, "R3 resumes from edge k+1", pci_o, 5'h1f);
      at_neg(3);

      // R6 / R9: global output enable
      oe = 1'b0; #1;
      chk({gen_drv_o, pcif_drv_o, pci_drv_o, ref_drv_o} == '0, "R6 oe low releases all",
          {gen_drv_o, pcif_drv_o, pci_drv_o, ref_drv_o}, 0);
      @(posedge clk); #1;
      chk(pcif_o == 1'b1, "R9 clock value runs while released", pcif_o, 1);
      at_neg(1); oe = 1'b1; #1;
      chk(pcif_drv_o == 1'b1, "R6 oe high drives", pcif_drv_o, 1);

      // R7: mode field codes
      at_neg(1); cfg_mode = 2'b11; #1;
      chk({gen_drv_o, pcif_drv_o, pci_drv_o} == '0, "R7 mode 11 releases",
          {gen_drv_o, pcif_drv_o, pci_drv_o}, 0);
      at_neg(3); cfg_mode = 2'b10; #1;
      chk(pci_drv_o == '1, "R7 mode 10 drives", pci_drv_o, 5'h1f);
      at_neg(3); cfg_mode = 2'b01; #1;
      chk(gen_drv_o == '1, "R7 mode 01 drives", gen_drv_o, 2'b11);
      at_neg(3); cfg_mode = 2'b00;

      // R9: disabled output stays driven
      cfg_gen_en = 2'b00; at_neg(8); #1;
      chk(gen_drv_o == '1, "R9 disabled pin still driven", gen_drv_o, 2'b11);
      cfg_gen_en = 2'b11; at_neg(8);

      // R5 / R8: strap cleared, stop ignored, shared pin drives the reference
      #1; rst_n = 1'b0; strap = 1'b0; stop_n = 1'b0;
      at_neg(3); #1; rst_n = 1'b1;
      at_neg(12);
      @(posedge clk); #1;
      chk(pci_o == '1, "R5 stop ignored without strap", pci_o, 5'h1f);
      chk(ref_drv_o == 1'b1, "R8 shared pin drives without strap", ref_drv_o, 1);
      at_neg(6); stop_n = 1'b1; at_neg(6);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #100000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule